// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the control and status registers of one GPIO bank made of up to four ports, each eight pins wide. A processor reaches it through a simple register bus with separate read and write strobes. For each pin the registers give a mode bit, an output-enable bit, an output value, an interrupt enable, an interrupt level bit and an interrupt status bit. These drive flat pin-indexed vectors toward the pads and toward a separate trigger-evaluation block. That trigger block reports detected events back on a per-pin set vector. Pin levels come in through a two-flop synchronizer and can be read back per port.

Each writable register also has a masked alias. Writing a word there updates only the pins named in the upper byte of the word, and each such pin takes the value given in the lower byte. Software can therefore change one pin without a read-modify-write sequence. Interrupt status bits are cleared by writing ones to a separate write-one-to-clear location.

Top module: `pin_bank_regs`

## Requirements
- R1: After reset every register is zero. pin_cfg, pin_oe, pin_out, int_en, int_lvl, int_sta and rdata all read as zero, so every pin starts as an input with interrupts off.
- R2: The byte address selects a register in bits [6:4] and a port in bits [3:2]. The register codes are 0 mode, 1 output enable, 2 output value, 3 input, 4 status, 5 interrupt enable, 6 level and 7 clear. A plain write stores wdata[7:0] into that port's register whole and ignores wdata[15:8]. From the cycle after the write strobe it shows on the outputs at bits [8*port+7 : 8*port].
- R3: Setting address bit 11 selects the masked alias of the same register. For each pin n, bit 8+n set loads bit n into pin n. Bit 8+n clear leaves pin n unchanged.
- R4: A write to the clear register (code 7) clears status bit n wherever wdata bit n is 1. Bits written as 0 have no effect. The clear register reads as zero.
- R5: A high bit of int_set sets the matching status bit on the next clock edge. If that bit is cleared in the same cycle, the set wins.
- R6: A read of the input register (code 3) returns the synchronized pin levels of that port. A change on pin_in is first returned by a read whose strobe is sampled on the third rising edge after the change.
- R7: rdata is registered. It carries the addressed value from the cycle after the read strobe, and bits [31:8] are always zero.
- R8: An address with any of bits [10:7] set, a port number at or above PORTS, or the alias of the input or clear register is unmapped. Such an address reads as zero and writes to it are ignored. Writes to the input register are also ignored.
- R9: Every register except the clear register reads back its stored value. A masked alias reads the same value as its plain register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data (mask in [15:8], values in [7:0]) |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| pin_in | input | PORTS*8 | Raw pin levels |
| int_set | input | PORTS*8 | Per-pin event pulses from the trigger logic |
| pin_cfg | output | PORTS*8 | Per-pin mode bits |
| pin_oe | output | PORTS*8 | Per-pin output enables |
| pin_out | output | PORTS*8 | Per-pin output values |
| int_en | output | PORTS*8 | Per-pin interrupt enables |
| int_lvl | output | PORTS*8 | Per-pin interrupt level bits |
| int_sta | output | PORTS*8 | Per-pin interrupt status |

## Verification
A write or an int_set pulse sampled on one rising edge shows on the register outputs right after that edge. The bench therefore checks those outputs at the falling edge that follows. Read data lands one edge after the read strobe. The monitor records which edges sampled a read and compares rdata at the next falling edge against the value the driver queued. Input reads are timed against the two synchronizer stages. A read sampled on the first or second edge after a pin change must still return the old level, and one sampled on the third edge returns the new level.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int PINS = 8;

  typedef enum logic [2:0] {
    REG_MODE = 3'd0,
    REG_OE   = 3'd1,
    REG_OUT  = 3'd2,
    REG_IN   = 3'd3,
    REG_STA  = 3'd4,
    REG_ENB  = 3'd5,
    REG_LVL  = 3'd6,
    REG_CLR  = 3'd7
  } gpb_reg_e;

  function automatic logic [PINS-1:0] merge_bits(
    input logic [PINS-1:0] old_v,
    input logic [PINS-1:0] new_v,
    input logic [PINS-1:0] sel
  );
    return (old_v & ~sel) | (new_v & sel);
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

  // R6: second stage always follows the first by exactly one edge
  a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    s2_q == $past(s1_q));
endmodule

// File: rtl/gpb_decode.sv
module gpb_decode
  import gpb_pkg::*;
#(
  parameter int PORTS = 4
) (
  input  logic [11:0]      addr,
  input  logic             wr_en,
  output logic [PORTS-1:0] wr_sel,
  output gpb_reg_e         reg_sel,
  output logic             masked,
  output logic [1:0]       port_idx,
  output logic             hit
);
  logic in_range;
  logic bad_alias;

  always_comb begin
    reg_sel   = gpb_reg_e'(addr[6:4]);
    port_idx  = addr[3:2];
    masked    = addr[11];
    in_range  = (addr[10:7] == 4'h0) && ({1'b0, port_idx} < 3'(PORTS));
    bad_alias = masked && ((reg_sel == REG_IN) || (reg_sel == REG_CLR));
    hit       = in_range && !bad_alias;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_sel
    assign wr_sel[p] = wr_en && hit && (port_idx == 2'(p));
  end
endmodule

// File: rtl/gpb_port.sv
module gpb_port
  import gpb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  gpb_reg_e        reg_sel,
  input  logic            masked,
  input  logic [15:0]     wdata,
  input  logic [PINS-1:0] set_evt,
  output logic [PINS-1:0] mode_q,
  output logic [PINS-1:0] oe_q,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] enb_q,
  output logic [PINS-1:0] lvl_q,
  output logic [PINS-1:0] sta_q
);
  logic [PINS-1:0] sel, val, clr_bits;
  logic [PINS-1:0] mode_d, oe_d, out_d, enb_d, lvl_d, sta_d;
  logic            mode_en, oe_en, out_en, enb_en, lvl_en, sta_en;

  always_comb begin
    val      = wdata[PINS-1:0];
    sel      = masked ? wdata[PINS+7:8] : '1;
    mode_en  = we && (reg_sel == REG_MODE);
    oe_en    = we && (reg_sel == REG_OE);
    out_en   = we && (reg_sel == REG_OUT);
    enb_en   = we && (reg_sel == REG_ENB);
    lvl_en   = we && (reg_sel == REG_LVL);
    clr_bits = (we && (reg_sel == REG_CLR)) ? val : '0;
    sta_en   = (we && ((reg_sel == REG_STA) || (reg_sel == REG_CLR))) || (|set_evt);
    mode_d   = merge_bits(mode_q, val, sel);
    oe_d     = merge_bits(oe_q, val, sel);
    out_d    = merge_bits(out_q, val, sel);
    enb_d    = merge_bits(enb_q, val, sel);
    lvl_d    = merge_bits(lvl_q, val, sel);
    sta_d    = (we && (reg_sel == REG_STA)) ? merge_bits(sta_q, val, sel) : sta_q;
    sta_d    = (sta_d & ~clr_bits) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      oe_q   <= '0;
      out_q  <= '0;
      enb_q  <= '0;
      lvl_q  <= '0;
      sta_q  <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (oe_en)   oe_q   <= oe_d;
      if (out_en)  out_q  <= out_d;
      if (enb_en)  enb_q  <= enb_d;
      if (lvl_en)  lvl_q  <= lvl_d;
      if (sta_en)  sta_q  <= sta_d;
    end
  end

  // R3: pins outside the mask keep their value on a masked write
  a_r3_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (we && masked && reg_sel == REG_OE) |=>
      (((oe_q ^ $past(oe_q)) & ~$past(wdata[PINS+7:8])) == '0));

  // R4: bits written as one to the clear register are zero afterwards (no set event)
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we && reg_sel == REG_CLR) |=>
      ((sta_q & $past(wdata[PINS-1:0] & ~set_evt)) == '0));

  // R5: an event always leaves its status bit set
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((sta_q & $past(set_evt)) == $past(set_evt)));
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import gpb_pkg::*;
#(
  parameter int PORTS = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [11:0]        addr,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  input  logic               rd_en,
  output logic [31:0]        rdata,
  input  logic [PORTS*8-1:0] pin_in,
  input  logic [PORTS*8-1:0] int_set,
  output logic [PORTS*8-1:0] pin_cfg,
  output logic [PORTS*8-1:0] pin_oe,
  output logic [PORTS*8-1:0] pin_out,
  output logic [PORTS*8-1:0] int_en,
  output logic [PORTS*8-1:0] int_lvl,
  output logic [PORTS*8-1:0] int_sta
);
  localparam int NPINS = PORTS * PINS;

  logic             rst_m_q, rst_n;
  logic [PORTS-1:0] wr_sel;
  gpb_reg_e         reg_sel;
  logic             masked, hit;
  logic [1:0]       port_idx;
  logic [NPINS-1:0] pin_sync;
  logic [PINS-1:0]  rd_mux;
  logic [31:0]      rdata_q;
  logic [PINS-1:0]  mode_a [PORTS];
  logic [PINS-1:0]  oe_a   [PORTS];
  logic [PINS-1:0]  out_a  [PORTS];
  logic [PINS-1:0]  enb_a  [PORTS];
  logic [PINS-1:0]  lvl_a  [PORTS];
  logic [PINS-1:0]  sta_a  [PORTS];
  logic [PINS-1:0]  in_a   [PORTS];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_m_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_n   <= rst_m_q;
    end
  end

  gpb_decode #(.PORTS(PORTS)) u_dec (
    .addr(addr), .wr_en(wr_en), .wr_sel(wr_sel), .reg_sel(reg_sel),
    .masked(masked), .port_idx(port_idx), .hit(hit)
  );

  gpb_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpb_port u_port (
      .clk(clk), .rst_n(rst_n), .we(wr_sel[p]), .reg_sel(reg_sel),
      .masked(masked), .wdata(wdata[15:0]),
      .set_evt(int_set[p*PINS +: PINS]),
      .mode_q(mode_a[p]), .oe_q(oe_a[p]), .out_q(out_a[p]),
      .enb_q(enb_a[p]), .lvl_q(lvl_a[p]), .sta_q(sta_a[p])
    );
    assign in_a[p]                 = pin_sync[p*PINS +: PINS];
    assign pin_cfg[p*PINS +: PINS] = mode_a[p];
    assign pin_oe[p*PINS +: PINS]  = oe_a[p];
    assign pin_out[p*PINS +: PINS] = out_a[p];
    assign int_en[p*PINS +: PINS]  = enb_a[p];
    assign int_lvl[p*PINS +: PINS] = lvl_a[p];
    assign int_sta[p*PINS +: PINS] = sta_a[p];
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (reg_sel)
        REG_MODE: rd_mux = mode_a[port_idx];
        REG_OE:   rd_mux = oe_a[port_idx];
        REG_OUT:  rd_mux = out_a[port_idx];
        REG_IN:   rd_mux = in_a[port_idx];
        REG_STA:  rd_mux = sta_a[port_idx];
        REG_ENB:  rd_mux = enb_a[port_idx];
        REG_LVL:  rd_mux = lvl_a[port_idx];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= {{(32-PINS){1'b0}}, rd_mux};
    end
  end

  assign rdata = rdata_q;

  // R8: an unmapped read returns zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == 32'h0));

  // R7: upper read bits stay zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:PINS] == '0);
endmodule

// File: tb/pin_bank_regs_test.sv
module pin_bank_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] int_set = '0;
  logic [31:0] pin_cfg, pin_oe, pin_out, int_en, int_lvl, int_sta;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_pend = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank_regs uut (
    .clk(clk), .rst_ni(rst_ni), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .int_set(int_set),
    .pin_cfg(pin_cfg), .pin_oe(pin_oe), .pin_out(pin_out),
    .int_en(int_en), .int_lvl(int_lvl), .int_sta(int_sta)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // monitor: a read sampled on an edge is compared at the next falling edge
  always @(posedge clk) mon_pend <= rd_en;
  always @(negedge clk) begin
    if (mon_pend) begin
      if (exp_q.size() == 0) begin
        check("scoreboard-empty", rdata, 32'hx);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 int_sta", int_sta, 32'h0);
    check("R1 int_en", int_en | int_lvl | pin_cfg, 32'h0);
    do_read(12'h000, 32'h0, "R1 mode read");

    // R2 plain writes
    do_write(12'h014, 32'h0000_00A5);
    check("R2 oe port1", pin_oe, 32'h0000_A500);
    do_read(12'h014, 32'h0000_00A5, "R9 oe readback");
    do_write(12'h02C, 32'h0000_003C);
    check("R2 out port3", pin_out, 32'h3C00_0000);
    do_write(12'h008, 32'h0000_0077);
    check("R2 mode port2", pin_cfg, 32'h0077_0000);
    do_write(12'h068, 32'h0000_0055);
    check("R2 level port2", int_lvl, 32'h0055_0000);

    // R3 masked alias
    do_write(12'h814, 32'h0000_0F0A);
    check("R3 masked oe", pin_oe, 32'h0000_AA00);
    do_write(12'h814, 32'h0000_00FF);
    check("R3 empty mask", pin_oe, 32'h0000_AA00);
    do_write(12'h85C, 32'h0000_F0FF);
    check("R3 masked enable", int_en, 32'hF000_0000);
    do_read(12'h814, 32'h0000_00AA, "R9 alias readback");
    // R2 plain write ignores the mask byte
    do_write(12'h010, 32'h0000_FF12);
    check("R2 plain ignores mask", pin_oe, 32'h0000_AA12);

    // R5 status set by events
    int_set = 32'h0000_0381;
    @(negedge clk);
    int_set = '0;
    check("R5 set", int_sta, 32'h0000_0381);
    do_read(12'h040, 32'h0000_0081, "R5 status port0");
    do_read(12'h044, 32'h0000_0003, "R5 status port1");

    // R4 write-one-to-clear
    do_write(12'h070, 32'h0000_0001);
    check("R4 clear bit0", int_sta, 32'h0000_0380);
    do_read(12'h070, 32'h0, "R4 clear reads zero");
    do_write(12'h074, 32'h0000_0000);
    check("R4 zero no effect", int_sta, 32'h0000_0380);

    // R5 set wins over clear
    int_set = 32'h0000_0080;
    addr = 12'h070; wdata = 32'h0000_0080; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; int_set = '0;
    check("R5 set beats clear", int_sta, 32'h0000_0380);
    do_write(12'h070, 32'h0000_0080);
    check("R4 clear bit7", int_sta, 32'h0000_0300);

    // R3 masked status write
    do_write(12'h844, 32'h0000_0201);
    check("R3 masked status", int_sta, 32'h0000_0100);

    // R6 input path latency
    pin_in = 32'hDEAD_BEEF;
    do_read(12'h038, 32'h0, "R6 edge1 old");
    do_read(12'h038, 32'h0, "R6 edge2 old");
    do_read(12'h038, 32'h0000_00AD, "R6 edge3 new");
    do_read(12'h030, 32'h0000_00EF, "R6 port0 input");

    // R8 unmapped and read-only
    do_write(12'h090, 32'h0000_00FF);
    check("R8 unmapped write", pin_oe, 32'h0000_AA12);
    do_read(12'h090, 32'h0, "R8 unmapped read");
    do_read(12'h830, 32'h0, "R8 input alias read");
    do_write(12'h870, 32'h0000_FFFF);
    check("R8 clear alias ignored", int_sta, 32'h0000_0100);
    do_write(12'h030, 32'h0000_0000);
    do_read(12'h030, 32'h0000_00EF, "R8 input write ignored");
    do_read(12'h02C, 32'h0000_003C, "R7 out readback");

    repeat (2) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule